// File: doc/BRIEF.md
# Uncached Load Entry Controller

This block tracks a single load that must bypass the cache. After allocation it captures the load address and presents a request on a memory port. It then waits for the matching response, keeps the returned data in a register, and offers that data to the load pipeline through a valid/ready writeback port.

A pipeline flush can arrive at any time. How the flush is handled depends on the current state. Before the request has been accepted, the flush suppresses the request and releases the entry in the same cycle. After the request has gone out, the entry cannot be dropped until its response returns, because that would leave a response with no owner. In that case the flush is recorded in a flag. The flag turns the arriving response into a release instead of a writeback. A flush during a pending writeback cancels the writeback at once. The flag is always cleared when the entry goes back to idle, so a flush can never affect a later load.

Top module: `ucld_entry_ctrl`

## Requirements
- R1: After reset the entry is idle: `alloc_ready` is 1 and `mreq_valid`, `mresp_ready`, `wb_valid` and `flush_done` are 0.
- R2: `alloc_ready` is 1 only while idle, and an allocation is taken only then. An allocation that arrives in the same cycle as `flush_in` is dropped: `flush_done` is 1 in that cycle, and no request follows.
- R3: After allocation the next cycle shows `mreq_valid`=1 with the captured address. The address stays unchanged until `mreq_ready` is seen. The handshake then moves the entry to waiting for a response.
- R4: A flush while the request is pending forces `mreq_valid` to 0 and `flush_done` to 1 in that cycle. The entry is idle in the next cycle.
- R5: While a response is outstanding (`mresp_ready`=1), a flush does not release the entry. The entry stays until `mresp_valid`. If a flush was seen at any point during that wait, including the response cycle, the response drops the entry: `flush_done` is 1 and no writeback follows.
- R6: An unflushed response captures `mresp_data`. From the next cycle `wb_valid` is 1 with that data, held stable until `wb_ready`. The entry then returns to idle.
- R7: A flush during a pending writeback forces `wb_valid` to 0 and `flush_done` to 1 in that cycle. The entry returns to idle.
- R8: A recorded flush never outlives its entry. After a flushed response, the next entry's unflushed response produces a normal writeback.
- R9: `mresp_ready` is 1 only while a response is outstanding. A `mresp_valid` at any other time is ignored and produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New uncached load offered |
| alloc_ready | output | 1 | Entry is free to accept a load |
| alloc_addr | input | ADDR_W | Address of the offered load |
| flush_in | input | 1 | Pipeline flush trigger |
| flush_done | output | 1 | Entry released by a flush this cycle |
| mreq_valid | output | 1 | Request to the uncached memory port |
| mreq_ready | input | 1 | Memory port accepts the request |
| mreq_addr | output | ADDR_W | Request address |
| mresp_valid | input | 1 | Response from memory |
| mresp_ready | output | 1 | Entry waiting for a response |
| mresp_data | input | DATA_W | Response data |
| wb_valid | output | 1 | Load result offered to the pipeline |
| wb_ready | input | 1 | Pipeline accepts the result |
| wb_data | output | DATA_W | Load result |

## Verification
The hardest case to reach is a flush that lands while the response is still outstanding and is followed, cycles later, by the response. After that, a fresh entry must complete a normal writeback, which shows that the stored flag did not leak. A directed sequence builds this exact ordering and then runs a clean load. Random stimulus with a low flush rate and sparse responses covers the other timings, such as a flush coinciding with the response or with an allocation. Every cycle is compared against a bench model written from the requirements.

// File: rtl/ucld_pkg.sv
package ucld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2,
        ST_WAIT = 2'd3
    } ucld_state_e;

    typedef struct packed {
        ucld_state_e st;
        logic        kill;
    } ucld_ctl_t;

    localparam ucld_ctl_t CTL_RESET = '{st: ST_IDLE, kill: 1'b0};

endpackage

// File: rtl/ucld_ctl.sv
module ucld_ctl
    import ucld_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alloc_valid,
    input  logic        flush_in,
    input  logic        mreq_ready,
    input  logic        mresp_valid,
    input  logic        wb_ready,
    output logic        alloc_ready,
    output logic        alloc_take,
    output logic        mreq_valid,
    output logic        mresp_ready,
    output logic        resp_take,
    output logic        wb_valid,
    output logic        flush_done,
    output ucld_state_e st_q,
    output logic        kill_q
);

    ucld_ctl_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        alloc_ready = 1'b0;
        alloc_take  = 1'b0;
        mreq_valid  = 1'b0;
        mresp_ready = 1'b0;
        resp_take   = 1'b0;
        wb_valid    = 1'b0;
        flush_done  = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                alloc_ready = 1'b1;
                if (alloc_valid) begin
                    if (flush_in) begin
                        flush_done = 1'b1;
                    end else begin
                        alloc_take = 1'b1;
                        nxt_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (flush_in) begin
                    flush_done = 1'b1;
                    nxt_d.st   = ST_IDLE;
                end else begin
                    mreq_valid = 1'b1;
                    if (mreq_ready) begin
                        nxt_d.st = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                mresp_ready = 1'b1;
                nxt_d.kill  = cur_q.kill | flush_in;
                if (mresp_valid) begin
                    nxt_d.kill = 1'b0;
                    if (flush_in || cur_q.kill) begin
                        flush_done = 1'b1;
                        nxt_d.st   = ST_IDLE;
                    end else begin
                        resp_take = 1'b1;
                        nxt_d.st  = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (flush_in) begin
                    flush_done = 1'b1;
                    nxt_d.st   = ST_IDLE;
                end else begin
                    wb_valid = 1'b1;
                    if (wb_ready) begin
                        nxt_d.st = ST_IDLE;
                    end
                end
            end
            default: nxt_d = CTL_RESET;
        endcase
        if (nxt_d.st == ST_IDLE) begin
            nxt_d.kill = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= CTL_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_q   = cur_q.st;
    assign kill_q = cur_q.kill;

endmodule

// File: rtl/ucld_hold.sv
module ucld_hold #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int HOLD_W = ADDR_W + DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (addr_we) begin
            hold_d.addr = addr_in;
        end
        if (data_we) begin
            hold_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= hold_t'({HOLD_W{1'b0}});
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_q = hold_q.addr;
    assign data_q = hold_q.data;

endmodule

// File: rtl/ucld_entry_ctrl.sv
module ucld_entry_ctrl
    import ucld_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              flush_in,
    output logic              flush_done,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    input  logic              mresp_valid,
    output logic              mresp_ready,
    input  logic [DATA_W-1:0] mresp_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [DATA_W-1:0] wb_data
);

    logic        alloc_take;
    logic        resp_take;
    ucld_state_e st_q;
    logic        kill_q;

    ucld_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .flush_in    (flush_in),
        .mreq_ready  (mreq_ready),
        .mresp_valid (mresp_valid),
        .wb_ready    (wb_ready),
        .alloc_ready (alloc_ready),
        .alloc_take  (alloc_take),
        .mreq_valid  (mreq_valid),
        .mresp_ready (mresp_ready),
        .resp_take   (resp_take),
        .wb_valid    (wb_valid),
        .flush_done  (flush_done),
        .st_q        (st_q),
        .kill_q      (kill_q)
    );

    ucld_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (alloc_take),
        .addr_in (alloc_addr),
        .data_we (resp_take),
        .data_in (mresp_data),
        .addr_q  (mreq_addr),
        .data_q  (wb_data)
    );

endmodule

// File: rtl/ucld_entry_chk.sv
module ucld_entry_chk
    import ucld_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_ready,
    input logic              flush_in,
    input logic              flush_done,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic              mresp_valid,
    input logic              mresp_ready,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [DATA_W-1:0] wb_data,
    input ucld_state_e       st_q,
    input logic              kill_q
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready |-> (!mreq_valid && !mresp_ready && !wb_valid));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> ($stable(mreq_addr) && (mreq_valid || flush_done)));

    // R4
    req_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REQ && flush_in) |=> alloc_ready);

    // R5
    resp_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mresp_ready && !mresp_valid) |=> mresp_ready);

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> ($stable(wb_data) && (wb_valid || flush_done)));

    // R7
    wait_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && flush_in) |-> (!wb_valid && flush_done));

    // R8
    no_stale_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready |-> !kill_q);

endmodule

bind ucld_entry_ctrl ucld_entry_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .flush_in    (flush_in),
    .flush_done  (flush_done),
    .mreq_valid  (mreq_valid),
    .mreq_ready  (mreq_ready),
    .mreq_addr   (mreq_addr),
    .mresp_valid (mresp_valid),
    .mresp_ready (mresp_ready),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_data     (wb_data),
    .st_q        (st_q),
    .kill_q      (kill_q)
);

// File: tb/sim_ucld_entry_ctrl.sv
module sim_ucld_entry_ctrl;

    localparam int AW = 48;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_ready;
    logic [AW-1:0] alloc_addr = '0;
    logic          flush_in = 1'b0;
    logic          flush_done;
    logic          mreq_valid;
    logic          mreq_ready = 1'b0;
    logic [AW-1:0] mreq_addr;
    logic          mresp_valid = 1'b0;
    logic          mresp_ready;
    logic [DW-1:0] mresp_data = '0;
    logic          wb_valid;
    logic          wb_ready = 1'b0;
    logic [DW-1:0] wb_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ucld_entry_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk (clk), .rst_n (rst_n),
        .alloc_valid (alloc_valid), .alloc_ready (alloc_ready), .alloc_addr (alloc_addr),
        .flush_in (flush_in), .flush_done (flush_done),
        .mreq_valid (mreq_valid), .mreq_ready (mreq_ready), .mreq_addr (mreq_addr),
        .mresp_valid (mresp_valid), .mresp_ready (mresp_ready), .mresp_data (mresp_data),
        .wb_valid (wb_valid), .wb_ready (wb_ready), .wb_data (wb_data)
    );

    // bench model: 0 idle, 1 request, 2 response, 3 writeback
    int            m_st = 0;
    bit            m_kill = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic string flush_tag(input int st);
        case (st)
            1: return "R4";
            2: return "R5";
            3: return "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic bit exp_flush(input int st, input bit k, input bit a,
                                     input bit f, input bit rv);
        case (st)
            0: return a && f;
            1: return f;
            2: return rv && (f || k);
            default: return f;
        endcase
    endfunction

    task automatic compare_outputs();
        bit ev;
        check("R2", "alloc_ready", alloc_ready, m_st == 0);
        ev = (m_st == 1) && !flush_in;
        check(flush_in ? "R4" : "R3", "mreq_valid", mreq_valid, ev);
        if (ev) check("R3", "mreq_addr", mreq_addr, m_addr);
        check("R9", "mresp_ready", mresp_ready, m_st == 2);
        ev = (m_st == 3) && !flush_in;
        check(flush_in ? "R7" : "R6", "wb_valid", wb_valid, ev);
        if (ev) check("R6", "wb_data", wb_data, m_data);
        check(flush_tag(m_st), "flush_done", flush_done,
              exp_flush(m_st, m_kill, alloc_valid, flush_in, mresp_valid));
    endtask

    task automatic advance_model();
        int nst = m_st;
        bit nk = m_kill;
        case (m_st)
            0: if (alloc_valid && !flush_in) begin nst = 1; m_addr = alloc_addr; end
            1: if (flush_in) nst = 0; else if (mreq_ready) nst = 2;
            2: begin
                nk = m_kill | flush_in;
                if (mresp_valid) begin
                    if (flush_in || m_kill) nst = 0;
                    else begin nst = 3; m_data = mresp_data; end
                end
            end
            default: if (flush_in || wb_ready) nst = 0;
        endcase
        if (nst == 0) nk = 1'b0;
        m_st = nst;
        m_kill = nk;
    endtask

    task automatic cyc(input bit a, input bit f, input bit mr, input bit rv,
                       input bit wr, input logic [AW-1:0] ad, input logic [DW-1:0] rd);
        alloc_valid = a; flush_in = f; mreq_ready = mr; mresp_valid = rv;
        wb_ready = wr; alloc_addr = ad; mresp_data = rd;
        @(negedge clk);
        compare_outputs();
        advance_model();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        alloc_valid = 0; flush_in = 0; mreq_ready = 0; mresp_valid = 0; wb_ready = 0;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        failures++;
        checks++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        // R1: reset state
        #3;
        check("R1", "alloc_ready", alloc_ready, 1);
        check("R1", "mreq_valid", mreq_valid, 0);
        check("R1", "mresp_ready", mresp_ready, 0);
        check("R1", "wb_valid", wb_valid, 0);
        check("R1", "flush_done", flush_done, 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: allocation with flush is dropped
        cyc(1, 1, 0, 0, 0, 48'h1111, 0);
        quiet();
        check("R2", "mreq_valid after dropped alloc", mreq_valid, 0);

        // R3/R4: request stalls then flush
        cyc(1, 0, 0, 0, 0, 48'hABCD_0000_1234, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0);
        quiet();
        check("R4", "alloc_ready after req flush", alloc_ready, 1);

        // R5 then R8: flush while outstanding, late response, then clean load
        cyc(1, 0, 0, 0, 0, 48'h2222, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        quiet();
        check("R5", "entry held after flush", mresp_ready, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 64'hDEAD);
        quiet();
        check("R5", "no writeback after flushed resp", wb_valid, 0);
        cyc(1, 0, 0, 0, 0, 48'h3333, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 64'h0123_4567_89AB_CDEF);
        quiet();
        check("R8", "writeback after earlier flush", wb_valid, 1);
        check("R8", "writeback data", wb_data, 64'h0123_4567_89AB_CDEF);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R7: flush cancels pending writeback
        cyc(0, 1, 0, 0, 1, 0, 0);

        // R9: response outside the outstanding window ignored
        cyc(0, 0, 0, 1, 0, 0, 64'h5555);
        quiet();
        check("R9", "stray response no writeback", wb_valid, 0);

        // R6: normal load with writeback stall
        cyc(1, 0, 1, 0, 0, 48'h4444, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 64'h7777);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        quiet();
        check("R6", "idle after writeback", alloc_ready, 1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            cyc($urandom % 2, ($urandom % 8) == 0, $urandom % 2, ($urandom % 3) == 0,
                $urandom % 2, {$urandom, $urandom}, {$urandom, $urandom});
        end
        finish_run();
    end

endmodule